// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

This block recovers characters from a single asynchronous serial line. A clock enable, `sampleTick`, pulses at sixteen times the bit rate, and the receiver times every bit from it. The receiver looks for a falling edge on the line. It confirms the start bit halfway through the bit, samples each later bit at its centre, and assembles the data least significant bit first.

Line settings are applied at run time. They select a data length of 5 to 8 bits, switch a parity bit on or off, choose even or odd parity, and can force the parity bit to a fixed value (stick parity). Each finished character is written into a 16-entry receive FIFO. The parity, framing and break flags are stored with the character that produced them.

The host sees the character at the head of the FIFO, together with its flags, and advances the FIFO with a one-cycle read strobe. Two more status outputs are a data-ready flag and a sticky overrun flag. A clear strobe empties the FIFO, and the reset returns all state to idle.

Top module: `serial_rx_top`

## Requirements
- R1: A low level seen on a sample tick while idle begins a start bit. On the 8th following tick the line must still be low, or the receiver returns to idle and stores nothing.
- R2: `cfgDataLen` selects the data length: 00 for 5 bits, 01 for 6, 10 for 7 and 11 for 8. Bits are sampled every 16 ticks after the start-bit centre and placed LSB first. `rdData` bits above the length read 0.
- R3: When `cfgParityEn`=1 and `cfgStick`=0, one parity bit follows the data. With `cfgEvenSel`=1 the count of ones in the data plus the parity bit must be even. With `cfgEvenSel`=0 it must be odd. A mismatch sets the entry's parity error.
- R4: When `cfgParityEn`=1 and `cfgStick`=1, the parity bit must equal the inverse of `cfgEvenSel`: 1 when `cfgEvenSel`=0, and 0 when it is 1. Any other value sets the parity error.
- R5: When `cfgParityEn`=0, no parity bit is expected. The stop bit follows the last data bit, and the parity error is never set.
- R6: A stop bit sampled at 0 sets the entry's framing error. The character is still stored.
- R7: A frame whose data, parity bit (if any) and stop bit are all 0 is stored as one entry with data 0 and with both the break and framing flags set. The receiver does not look for a new start bit until the line has returned high, so a long low period gives exactly one entry.
- R8: The FIFO holds up to 16 characters in arrival order. `dataReady` is 1 whenever at least one is stored, and a one-cycle `rdPop` removes the head.
- R9: A character that completes while the FIFO holds 16 entries is discarded and sets `overrunErr`. The flag stays set until a clear or a reset.
- R10: A one-cycle `fifoClear` empties the FIFO and clears `overrunErr`. Reception continues afterwards.
- R11: After reset `dataReady` and `overrunErr` are 0, and the status outputs show no entry.
- R12: `parityErr`, `frameErr` and `breakFlag` give the flags of the entry at the FIFO head. They follow each entry to the head, and they are 0 while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, synchronous |
| sampleTick | input | 1 | Clock enable at 16x the bit rate |
| rxLine | input | 1 | Serial input line, idle high |
| cfgDataLen | input | 2 | Data length select (00=5 … 11=8) |
| cfgParityEn | input | 1 | Parity bit present |
| cfgEvenSel | input | 1 | Even parity select, or the inverse of the stick value |
| cfgStick | input | 1 | Fixed-value parity mode |
| fifoClear | input | 1 | Empty the FIFO and clear overrun |
| rdPop | input | 1 | Remove the head entry |
| rdData | output | 8 | Head character, zero-extended |
| dataReady | output | 1 | At least one character stored |
| parityErr | output | 1 | Head entry parity error |
| frameErr | output | 1 | Head entry framing error |
| breakFlag | output | 1 | Head entry break |
| overrunErr | output | 1 | Sticky overrun |

## Verification
The bench sweeps every data length against all five parity settings, using patterns that include all zeros and all ones. Each sweep also sends a frame with a flipped parity bit. A wrong data-length shift or a wrong parity sense shows up there as bad data or a missing or spurious parity error.

A short low glitch checks that an unconfirmed start stores nothing. A long low period checks that a break produces one entry and not a stream of them. Seventeen frames sent without reading check that the seventeenth is dropped, that the first sixteen keep their order, and that overrun stays set until a clear. A mix of good and bad frames checks that the flags travel with their own entries and do not leak onto neighbouring ones.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int MAX_DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAITHI
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearShift;
    logic takeData;
    logic takeParity;
    logic finish;
  } rxStrobe_t;

  typedef struct packed {
    logic [MAX_DATA_W-1:0] data;
    logic                  parityErr;
    logic                  frameErr;
    logic                  breakSeen;
  } rxEntry_t;
endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sampleTick,
  input  logic      lineBit,
  input  logic [1:0] cfgDataLen,
  input  logic      cfgParityEn,
  output rxStrobe_t strobe
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);

  rxState_t         state, stateNext;
  logic [CNT_W-1:0] tickCnt, cntNext;
  logic [2:0]       bitIdx, bitNext;
  logic [2:0]       lastBit;

  assign lastBit = {1'b1, cfgDataLen};

  always_comb begin
    stateNext = state;
    cntNext   = tickCnt;
    bitNext   = bitIdx;
    strobe    = '0;
    if (sampleTick) begin
      unique case (state)
        ST_IDLE: begin
          if (!lineBit) begin
            stateNext         = ST_START;
            cntNext           = '0;
            strobe.clearShift = 1'b1;
          end
        end
        ST_START: begin
          if (tickCnt == MID_CNT) begin
            cntNext = '0;
            bitNext = '0;
            stateNext = lineBit ? ST_IDLE : ST_DATA;
          end else begin
            cntNext = tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (tickCnt == LAST_CNT) begin
            cntNext         = '0;
            strobe.takeData = 1'b1;
            if (bitIdx == lastBit) stateNext = cfgParityEn ? ST_PAR : ST_STOP;
            else                   bitNext   = bitIdx + 1'b1;
          end else begin
            cntNext = tickCnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (tickCnt == LAST_CNT) begin
            cntNext           = '0;
            strobe.takeParity = 1'b1;
            stateNext         = ST_STOP;
          end else begin
            cntNext = tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tickCnt == LAST_CNT) begin
            cntNext       = '0;
            strobe.finish = 1'b1;
            stateNext     = lineBit ? ST_IDLE : ST_WAITHI;
          end else begin
            cntNext = tickCnt + 1'b1;
          end
        end
        ST_WAITHI: begin
          if (lineBit) stateNext = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNext;
      tickCnt <= cntNext;
      bitIdx  <= bitNext;
    end
  end

  // R1: a start not confirmed at mid-bit is abandoned
  a_r1_false_start: assert property (@(posedge clk) disable iff (rst)
    (sampleTick && state == ST_START && tickCnt == MID_CNT && lineBit) |=> state == ST_IDLE);

  // R7: after a low stop bit the receiver holds until the line is high
  a_r7_hold_low: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAITHI && !lineBit) |=> state == ST_WAITHI);

  // R2: at most one datapath strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

  // R6: a frame completes only from the stop state
  a_r6_finish_from_stop: assert property (@(posedge clk) disable iff (rst)
    strobe.finish |=> ($past(state) == ST_STOP));
endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxLine,
  input  rxStrobe_t  strobe,
  input  logic [1:0] cfgDataLen,
  input  logic       cfgParityEn,
  input  logic       cfgEvenSel,
  input  logic       cfgStick,
  output logic       lineBit,
  output rxEntry_t   entry
);
  logic [SYNC_STAGES-1:0]  syncChain;
  logic [MAX_DATA_W-1:0]   shiftReg;
  logic                    parBit;
  logic [MAX_DATA_W-1:0]   aligned;
  logic [1:0]              shAmt;
  logic                    dataOnes;

  always_ff @(posedge clk) begin
    if (rst) syncChain <= '1;
    else     syncChain <= {syncChain[SYNC_STAGES-2:0], rxLine};
  end
  assign lineBit = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.clearShift) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.takeData) begin
      shiftReg <= {lineBit, shiftReg[MAX_DATA_W-1:1]};
    end else if (strobe.takeParity) begin
      parBit <= lineBit;
    end
  end

  // a short word sits in the top bits; move it down
  assign shAmt    = 2'd3 - cfgDataLen;
  assign aligned  = shiftReg >> shAmt;
  assign dataOnes = ^aligned;

  always_comb begin
    entry.data = aligned;
    if (!cfgParityEn)  entry.parityErr = 1'b0;
    else if (cfgStick) entry.parityErr = (parBit != !cfgEvenSel);
    else               entry.parityErr = dataOnes ^ parBit ^ !cfgEvenSel;
    entry.frameErr  = !lineBit;
    entry.breakSeen = !lineBit && (aligned == '0) && (!cfgParityEn || !parBit);
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     clear,
  input  logic     push,
  input  rxEntry_t pushEntry,
  input  logic     pop,
  output rxEntry_t headEntry,
  output logic     notEmpty,
  output logic     overrun
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rxEntry_t         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             full, doPush, doPop;

  assign full     = (count == CNT_W'(DEPTH));
  assign notEmpty = (count != '0);
  assign doPush   = push && !full;
  assign doPop    = pop && notEmpty;
  assign headEntry = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !clear && !rst) mem[wrPtr] <= pushEntry;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
      if (push && full) overrun <= 1'b1;
    end
  end

  // R9: a push into a full FIFO raises overrun
  a_r9_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (push && full && !clear) |=> overrun);

  // R10: clear leaves the FIFO empty with overrun low
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!notEmpty && !overrun));

  // R8: a lone pop removes exactly one entry
  a_r8_pop_one: assert property (@(posedge clk) disable iff (rst)
    (pop && notEmpty && !push && !clear) |=> count == $past(count) - 1'b1);

  // R9: overrun is sticky until clear
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !clear) |=> overrun);
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic [1:0] cfgDataLen,
  input  logic       cfgParityEn,
  input  logic       cfgEvenSel,
  input  logic       cfgStick,
  input  logic       fifoClear,
  input  logic       rdPop,
  output logic [7:0] rdData,
  output logic       dataReady,
  output logic       parityErr,
  output logic       frameErr,
  output logic       breakFlag,
  output logic       overrunErr
);
  rxStrobe_t strobe;
  rxEntry_t  newEntry, headEntry;
  logic      lineBit, notEmpty;

  srx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rst(rst), .sampleTick(sampleTick), .lineBit(lineBit),
    .cfgDataLen(cfgDataLen), .cfgParityEn(cfgParityEn), .strobe(strobe)
  );

  srx_datapath #(.SYNC_STAGES(2)) u_dp (
    .clk(clk), .rst(rst), .rxLine(rxLine), .strobe(strobe),
    .cfgDataLen(cfgDataLen), .cfgParityEn(cfgParityEn),
    .cfgEvenSel(cfgEvenSel), .cfgStick(cfgStick),
    .lineBit(lineBit), .entry(newEntry)
  );

  srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clear(fifoClear), .push(strobe.finish),
    .pushEntry(newEntry), .pop(rdPop), .headEntry(headEntry),
    .notEmpty(notEmpty), .overrun(overrunErr)
  );

  assign dataReady = notEmpty;
  assign rdData    = headEntry.data & {8{notEmpty}};
  assign parityErr = headEntry.parityErr & notEmpty;
  assign frameErr  = headEntry.frameErr & notEmpty;
  assign breakFlag = headEntry.breakSeen & notEmpty;

  // R12: no flag shows while the FIFO is empty
  a_r12_flags_quiet: assert property (@(posedge clk) disable iff (rst)
    !dataReady |-> !(parityErr || frameErr || breakFlag));
endmodule

// File: tb/serial_rx_top_bench.sv
`timescale 1ns/1ps
module serial_rx_top_bench;
  localparam int BIT_CLKS = 32;  // 16 ticks, one tick every 2 clocks

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, tickPh, rxLine, cfgParityEn, cfgEvenSel, cfgStick, fifoClear, rdPop;
  logic [1:0] cfgDataLen;
  logic [7:0] rdData;
  logic dataReady, parityErr, frameErr, breakFlag, overrunErr;
  int checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) tickPh <= rst ? 1'b0 : ~tickPh;

  serial_rx_top u_serial_rx_top (
    .clk(clk), .rst(rst), .sampleTick(tickPh), .rxLine(rxLine),
    .cfgDataLen(cfgDataLen), .cfgParityEn(cfgParityEn), .cfgEvenSel(cfgEvenSel),
    .cfgStick(cfgStick), .fifoClear(fifoClear), .rdPop(rdPop), .rdData(rdData),
    .dataReady(dataReady), .parityErr(parityErr), .frameErr(frameErr),
    .breakFlag(breakFlag), .overrunErr(overrunErr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic holdBit(input logic v);
    @(negedge clk) rxLine = v;
    repeat (BIT_CLKS - 1) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int len, input logic parOn,
                           input logic parBit, input logic stopBit);
    holdBit(1'b0);
    for (int i = 0; i < len; i++) holdBit(d[i]);
    if (parOn) holdBit(parBit);
    holdBit(stopBit);
    holdBit(1'b1);
    holdBit(1'b1);
  endtask

  // mode: 0 none, 1 even, 2 odd, 3 stick one, 4 stick zero
  task automatic setCfg(input int len, input int mode);
    cfgDataLen  = 2'(len - 5);
    cfgParityEn = (mode != 0);
    cfgStick    = (mode >= 3);
    cfgEvenSel  = (mode == 1) || (mode == 4);
  endtask

  function automatic logic parFor(input logic [7:0] d, input int mode);
    case (mode)
      1: return ^d;
      2: return ~^d;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic readHead(input string req, input int d, input int p, input int f, input int b);
    @(negedge clk);
    check({req, " ready"}, dataReady, 1);
    check({req, " data"}, rdData, d);
    check({req, " parity"}, parityErr, p);
    check({req, " frame"}, frameErr, f);
    check({req, " break"}, breakFlag, b);
    rdPop = 1'b1;
    @(negedge clk) rdPop = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk) fifoClear = 1'b1;
    @(negedge clk) fifoClear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; rxLine = 1; rdPop = 0; fifoClear = 0;
    setCfg(8, 0);
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 ready", dataReady, 0);
    check("R11 overrun", overrunErr, 0);
    check("R11 flags", {parityErr, frameErr, breakFlag}, 0);

    // R2 R3 R4 R5: sweep lengths and parity modes
    for (int len = 5; len <= 8; len++) begin
      for (int mode = 0; mode <= 4; mode++) begin
        setCfg(len, mode);
        for (int k = 0; k < 6; k++) begin
          logic [7:0] mask, d;
          mask = 8'((1 << len) - 1);
          d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 37 + len * 11 + mode * 53);
          d = d & mask;
          sendFrame(d, len, mode != 0, parFor(d, mode), 1'b1);
          readHead(mode == 0 ? "R5 R2" : mode <= 2 ? "R3 R2" : "R4 R2", d, 0, 0, 0);
        end
        if (mode != 0) begin
          logic [7:0] d2;
          d2 = 8'(8'h5B & 8'((1 << len) - 1));
          sendFrame(d2, len, 1'b1, ~parFor(d2, mode), 1'b1);
          readHead(mode <= 2 ? "R3 bad parity" : "R4 bad parity", d2, 1, 0, 0);
        end
        @(negedge clk);
        check("R8 drained", dataReady, 0);
      end
    end

    // R6: framing error
    setCfg(8, 0);
    sendFrame(8'hA5, 8, 1'b0, 1'b0, 1'b0);
    readHead("R6 framing", 8'hA5, 0, 1, 0);

    // R7: long low period gives a single break entry
    setCfg(7, 1);
    @(negedge clk) rxLine = 1'b0;
    repeat (BIT_CLKS * 22) @(negedge clk);
    rxLine = 1'b1;
    repeat (BIT_CLKS * 3) @(negedge clk);
    readHead("R7 break", 0, 0, 1, 1);
    @(negedge clk);
    check("R7 single entry", dataReady, 0);

    // R1: short glitch is not a start
    setCfg(8, 0);
    @(negedge clk) rxLine = 1'b0;
    repeat (6) @(negedge clk);
    rxLine = 1'b1;
    repeat (BIT_CLKS * 12) @(negedge clk);
    check("R1 glitch ignored", dataReady, 0);
    sendFrame(8'h3C, 8, 1'b0, 1'b0, 1'b1);
    readHead("R1 recover", 8'h3C, 0, 0, 0);

    // R12: flags travel with their own entries
    setCfg(6, 2);
    sendFrame(8'h15, 6, 1'b1, parFor(8'h15, 2), 1'b1);
    sendFrame(8'h2A, 6, 1'b1, ~parFor(8'h2A, 2), 1'b1);
    sendFrame(8'h0F, 6, 1'b1, parFor(8'h0F, 2), 1'b0);
    sendFrame(8'h21, 6, 1'b1, parFor(8'h21, 2), 1'b1);
    readHead("R12 e0", 8'h15, 0, 0, 0);
    readHead("R12 e1", 8'h2A, 1, 0, 0);
    readHead("R12 e2", 8'h0F, 0, 1, 0);
    readHead("R12 e3", 8'h21, 0, 0, 0);

    // R8 R9: fill past 16
    setCfg(8, 0);
    for (int i = 0; i < 17; i++) sendFrame(8'(i + 8'h40), 8, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check("R9 overrun set", overrunErr, 1);
    for (int i = 0; i < 16; i++) readHead("R8 order", i + 8'h40, 0, 0, 0);
    @(negedge clk);
    check("R9 17th discarded", dataReady, 0);
    check("R9 overrun sticky", overrunErr, 1);
    pulseClear();
    @(negedge clk);
    check("R10 overrun cleared", overrunErr, 0);

    // R10: clear empties queued entries
    sendFrame(8'h11, 8, 1'b0, 1'b0, 1'b1);
    sendFrame(8'h22, 8, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check("R10 before clear", dataReady, 1);
    pulseClear();
    @(negedge clk);
    check("R10 emptied", dataReady, 0);
    sendFrame(8'h99, 8, 1'b0, 1'b0, 1'b1);
    readHead("R10 after clear", 8'h99, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule